// File: doc/BRIEF.md
# Gain Offset Saturate Accumulator

This block sits at the end of a pixel pipeline. Each cycle it can take one 8-bit pixel value together with an 8-bit weight. It scales the pixel by an unsigned fixed-point gain, adds a signed offset, and clamps the result to the 8-bit range. The clamped value then feeds three running totals: the plain sum, the sum of squares, and the sum of the value times its weight. Together these give the energy and cross terms that a normalized cross-correlation needs.

The totals are never cleared by the end of a run. They keep growing until an explicit clear pulse arrives, so several passes over a point list can be merged into one set of results. A two-bit select picks which total appears on the read port. The gain and offset are sampled together with each pixel, so a new setting applies from the next sample onward.

Top module: `pix_gain_accum`

## Requirements
- R1: The scaled value is floor(pix * gain / 256) + offset. Gain is a 16-bit unsigned number with 8 fractional bits (0x0100 = 1.0). Offset is a 9-bit two's-complement number (range -256 to 255).
- R2: A scaled value below 0 is clamped to 0, and a scaled value above 255 is clamped to 255.
- R3: The block keeps three 32-bit totals of the clamped value v: the sum of v, the sum of v*v, and the sum of v*weight. `rd_sel` selects the total shown on `rd_data`: 0 gives the sum of v, 1 the sum of squares, 2 the weighted sum, and 3 reads as zero.
- R4: The totals change only when a sample is added or a clear is applied. Idle cycles and the end of a run leave them unchanged, and a later run adds onto the earlier totals.
- R5: When `clr` is high at a rising edge, all three totals are zero after that edge. The sample presented in the same cycle is discarded, and so is any sample still inside the pipeline.
- R6: A sample can be accepted on every cycle, with no gaps needed. A sample captured at edge E0 is included in the totals after edge E2, the second edge after E0. It is not yet included after edge E1.
- R7: After synchronous reset, all three totals read zero and no sample is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_pix | input | 8 | Pixel value |
| in_p0 | input | 8 | Per-point weight |
| gain | input | 16 | Unsigned gain, 8 fractional bits |
| offset | input | 9 | Signed offset |
| clr | input | 1 | Clear all totals and drop pending samples |
| rd_sel | input | 2 | Total select |
| rd_data | output | 32 | Selected total |

## Verification
The hardest case to reach is a clear that overlaps samples at different depths of the pipeline. At that moment one sample is already inside the pipeline and another arrives alongside the clear. The stimulus sends a sample, then a clear together with a second sample on the very next cycle, then a third sample. It then checks that only the third sample shows up in the totals. Clamping at both ends is reached by gain and offset pairs that push the scaled value past 255 and below 0, including the largest gain with the most negative offset.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int PIX_W     = 8;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 8;
    localparam int OFS_W     = 9;
    localparam int ACC_W     = 32;
    localparam int NUM_SUMS  = 3;

    localparam int PROD_W    = PIX_W + GAIN_W;
    localparam int SCALED_W  = PROD_W - GAIN_FRAC;
    localparam int SUM_W     = SCALED_W + 2;
    localparam int SQ_W      = 2 * PIX_W;
    localparam int PIX_MAX   = (1 << PIX_W) - 1;
    localparam int SQ_MAX    = PIX_MAX * PIX_MAX;

    localparam int IDX_SUM   = 0;
    localparam int IDX_SQ    = 1;
    localparam int IDX_CROSS = 2;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [SQ_W-1:0]  term_t;
    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        SEL_SUM   = 2'd0,
        SEL_SQ    = 2'd1,
        SEL_CROSS = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef struct packed {
        logic valid;
        pix_t val;
        pix_t p0;
    } scaled_t;

    typedef struct packed {
        logic                      valid;
        logic [NUM_SUMS-1:0][SQ_W-1:0] term;
    } terms_t;

    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(PIX_MAX);
    localparam logic signed [SUM_W-1:0] SAT_LO = '0;

    function automatic pix_t clamp_pix(input logic signed [SUM_W-1:0] x);
        if (x < SAT_LO)
            return '0;
        else if (x > SAT_HI)
            return pix_t'(PIX_MAX);
        else
            return x[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/pga_scale.sv
module pga_scale
    import pga_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    in_valid,
    input  pix_t                    in_pix,
    input  pix_t                    in_p0,
    input  logic [GAIN_W-1:0]       gain,
    input  logic signed [OFS_W-1:0] offset,
    output scaled_t                 out
);

    logic [PROD_W-1:0]       prod;
    logic signed [SUM_W-1:0] biased;

    always_comb begin
        prod   = PROD_W'(in_pix) * PROD_W'(gain);
        biased = $signed({{(SUM_W-SCALED_W){1'b0}}, prod[PROD_W-1:GAIN_FRAC]})
               + SUM_W'(offset);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= '0;
        end else begin
            out.valid <= in_valid & ~clr;
            if (in_valid) begin
                out.val <= clamp_pix(biased);
                out.p0  <= in_p0;
            end
        end
    end

    // R5: a clear empties this stage on the next cycle
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out.valid);

    // R6: an accepted sample always reaches this stage one cycle later
    assert_accept_every_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr) |=> out.valid);

endmodule

// File: rtl/pga_terms.sv
module pga_terms
    import pga_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  scaled_t in,
    output terms_t  out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= '0;
        end else begin
            out.valid <= in.valid & ~clr;
            if (in.valid) begin
                out.term[IDX_SUM]   <= SQ_W'(in.val);
                out.term[IDX_SQ]    <= SQ_W'(in.val) * SQ_W'(in.val);
                out.term[IDX_CROSS] <= SQ_W'(in.val) * SQ_W'(in.p0);
            end
        end
    end

    // R3: a square of a clamped value never exceeds the largest 8-bit square
    assert_square_bound_R3: assert property (@(posedge clk) disable iff (rst)
        out.valid |-> (out.term[IDX_SQ] <= term_t'(SQ_MAX)));

    // R2: the plain term is always within the 8-bit range
    assert_value_range_R2: assert property (@(posedge clk) disable iff (rst)
        out.valid |-> (out.term[IDX_SUM] <= term_t'(PIX_MAX)));

    // R5: a clear empties this stage as well
    assert_clear_flush_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out.valid);

endmodule

// File: rtl/pga_accum.sv
module pga_accum
    import pga_pkg::*;
#(
    parameter int IN_W = SQ_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            add_en,
    input  logic [IN_W-1:0] addend,
    output acc_t            acc
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (add_en)
            acc <= acc + ACC_W'(addend);
    end

    // R5: the total reads zero right after a clear
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

    // R4: with nothing to add and no clear, the total holds
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !add_en) |=> $stable(acc));

endmodule

// File: rtl/pix_gain_accum.sv
module pix_gain_accum
    import pga_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_pix,
    input  logic [7:0]        in_p0,
    input  logic [15:0]       gain,
    input  logic signed [8:0] offset,
    input  logic              clr,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data
);

    scaled_t                       s1;
    terms_t                        s2;
    logic [NUM_SUMS-1:0][ACC_W-1:0] sums;

    pga_scale u_scale (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .in_valid (in_valid),
        .in_pix   (in_pix),
        .in_p0    (in_p0),
        .gain     (gain),
        .offset   (offset),
        .out      (s1)
    );

    pga_terms u_terms (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .in  (s1),
        .out (s2)
    );

    for (genvar gi = 0; gi < NUM_SUMS; gi++) begin : g_acc
        pga_accum #(.IN_W(SQ_W)) u_acc (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .add_en (s2.valid),
            .addend (s2.term[gi]),
            .acc    (sums[gi])
        );
    end

    always_comb begin
        case (sel_e'(rd_sel))
            SEL_SUM:   rd_data = sums[IDX_SUM];
            SEL_SQ:    rd_data = sums[IDX_SQ];
            SEL_CROSS: rd_data = sums[IDX_CROSS];
            default:   rd_data = '0;
        endcase
    end

    // R3: the unused select code reads as zero
    assert_unused_sel_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd3) |-> (rd_data == '0));

    // R7: nothing is pending in the first cycle after reset
    assert_reset_empty_R7: assert property (@(posedge clk)
        $past(rst) |-> (!s1.valid && !s2.valid));

endmodule

// File: tb/pix_gain_accum_bench.sv
`timescale 1ns/1ps
module pix_gain_accum_bench;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [7:0]        in_pix;
    logic [7:0]        in_p0;
    logic [15:0]       gain;
    logic signed [8:0] offset;
    logic              clr;
    logic [1:0]        rd_sel;
    logic [31:0]       rd_data;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pix_gain_accum u_pix_gain_accum (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_p0(in_p0), .gain(gain), .offset(offset), .clr(clr),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    localparam int NV = 8;
    localparam logic [7:0]        V_PIX [NV] = '{8'd100, 8'd200, 8'd50, 8'd10,
                                                 8'd255, 8'd7, 8'd0, 8'd128};
    localparam logic [7:0]        V_P0  [NV] = '{8'd3, 8'd2, 8'd9, 8'd4,
                                                 8'd1, 8'd10, 8'd5, 8'd2};
    localparam logic [15:0]       V_GN  [NV] = '{16'h0100, 16'h0180, 16'h0080, 16'h0100,
                                                 16'hFFFF, 16'h0240, 16'h0100, 16'h00C0};
    localparam logic signed [8:0] V_OF  [NV] = '{9'sd0, 9'sd0, -9'sd30, 9'sd20,
                                                 9'h100, 9'sd3, 9'sd255, -9'sd1};
    localparam int                V_EXP [NV] = '{100, 255, 0, 30, 255, 18, 255, 95};

    task automatic put(input logic [7:0] pix, input logic [7:0] p0,
                       input logic [15:0] g, input logic signed [8:0] o,
                       input logic v, input logic c);
        in_pix = pix; in_p0 = p0; gain = g; offset = o;
        in_valid = v; clr = c;
        @(posedge clk); #1;
        in_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        rd_sel = sel;
        #1;
        n_cmp++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, sel, rd_data, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        longint t_sum, t_sq, t_cr;
        rst = 1'b1; in_valid = 1'b0; in_pix = '0; in_p0 = '0;
        gain = 16'h0100; offset = '0; clr = 1'b0; rd_sel = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7: reset state
        check(2'd0, 32'd0, "R7 reset sum");
        check(2'd1, 32'd0, "R7 reset sq");
        check(2'd2, 32'd0, "R7 reset cross");

        // Table walk: one sample per clear. R1, R2 on values, R6 on latency
        for (int i = 0; i < NV; i++) begin
            put(8'd0, 8'd0, 16'h0100, 9'sd0, 1'b0, 1'b1);
            put(V_PIX[i], V_P0[i], V_GN[i], V_OF[i], 1'b1, 1'b0);
            idle(1);
            check(2'd0, 32'd0, "R6 not visible after one edge");
            idle(1);
            check(2'd0, 32'(V_EXP[i]), "R1 R2 sum");
            check(2'd1, 32'(V_EXP[i] * V_EXP[i]), "R3 square");
            check(2'd2, 32'(V_EXP[i] * int'(V_P0[i])), "R3 cross");
        end

        // Back-to-back stream: R6 one per cycle
        t_sum = 0; t_sq = 0; t_cr = 0;
        for (int i = 0; i < NV; i++) begin
            t_sum += V_EXP[i];
            t_sq  += V_EXP[i] * V_EXP[i];
            t_cr  += V_EXP[i] * int'(V_P0[i]);
        end
        put(8'd0, 8'd0, 16'h0100, 9'sd0, 1'b0, 1'b1);
        for (int i = 0; i < NV; i++)
            put(V_PIX[i], V_P0[i], V_GN[i], V_OF[i], 1'b1, 1'b0);
        idle(2);
        check(2'd0, 32'(t_sum), "R6 stream sum");
        check(2'd1, 32'(t_sq),  "R6 stream sq");
        check(2'd2, 32'(t_cr),  "R6 stream cross");

        // R4: idle holds, second run adds on
        idle(5);
        check(2'd0, 32'(t_sum), "R4 idle hold");
        for (int i = 0; i < NV; i++)
            put(V_PIX[i], V_P0[i], V_GN[i], V_OF[i], 1'b1, 1'b0);
        idle(2);
        check(2'd0, 32'(2 * t_sum), "R4 second run sum");
        check(2'd1, 32'(2 * t_sq),  "R4 second run sq");
        check(2'd2, 32'(2 * t_cr),  "R4 second run cross");

        // R3: unused select reads zero
        check(2'd3, 32'd0, "R3 unused select");

        // R5: in-flight sample and same-cycle sample both dropped
        put(8'd50, 8'd1, 16'h0100, 9'sd0, 1'b1, 1'b0);
        put(8'd100, 8'd1, 16'h0100, 9'sd0, 1'b1, 1'b1);
        check(2'd0, 32'd0, "R5 zero after clear");
        put(8'd10, 8'd3, 16'h0100, 9'sd0, 1'b1, 1'b0);
        idle(2);
        check(2'd0, 32'd10,  "R5 only later sample sum");
        check(2'd1, 32'd100, "R5 only later sample sq");
        check(2'd2, 32'd30,  "R5 only later sample cross");

        // Long full-scale run: R3 sums at width
        put(8'd0, 8'd0, 16'h0100, 9'sd0, 1'b0, 1'b1);
        for (int i = 0; i < 300; i++)
            put(8'd255, 8'd255, 16'h0100, 9'sd0, 1'b1, 1'b0);
        idle(2);
        check(2'd0, 32'd76500,    "R3 long sum");
        check(2'd1, 32'd19507500, "R3 long sq");
        check(2'd2, 32'd19507500, "R3 long cross");

        // R7: reset in the middle clears totals
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        check(2'd1, 32'd0, "R7 reset mid-run");

        summary();
    end

endmodule